// File: doc/BRIEF.md
# Polyphase I/Q Decimate-by-4 Low-Pass Filter

This block low-pass filters a complex baseband stream and keeps one output of every four inputs. In-phase and quadrature samples arrive together with a valid strobe at up to one per clock. Each channel is stored in four branch delay lines. Samples go to the branches in turn, and one branch is written per accepted sample. After every fourth accepted sample, the branch contents of both channels are copied into a hold window. A single pre-add/multiply/accumulate datapath then computes the I result and the Q result in four clock cycles, one after the other. The arithmetic therefore runs at the decimated rate and is shared by both channels.

The coefficient set is symmetric, so only its first half is supplied. Sample pairs that share a coefficient are added before the multiply, which halves the number of products. The full-precision sum is rounded and saturated to the output width. Both results are then presented together with a one-cycle valid pulse. The outputs equal a direct-form filter whose output is kept at every fourth sample instant.

A controller sequences the work through five named states. IDLE waits for a capture. I_LO and I_HI each add half of the I coefficient pairs. Q_LO and Q_HI do the same for Q. The transitions are IDLE→I_LO on a capture, I_LO→I_HI, I_HI→Q_LO and Q_LO→Q_HI unconditionally. Q_HI goes to I_LO when a capture coincides with it, and to IDLE otherwise.

Top module: `polydec4_iq_fir`

## Requirements
- R1: During and after reset, out_valid is 0, out_i and out_q are 0, the branch lines hold zeros, and the next four accepted samples form the first decimation group.
- R2: For every fourth accepted sample (the 4th, 8th, … since reset), out_valid is high for exactly one cycle, 4 clock edges after the edge that accepts that sample. It is never high at any other time.
- R3: With x[n] the I samples in acceptance order (n from 0), h[k] the NTAPS coefficients and missing samples taken as 0: at the pulse for sample 4m+3, out_i = sat(round((Σk h[k]·x[4m+3−k]) / 2^FRAC)).
- R4: out_q follows the same rule using only the Q samples. No I data reaches out_q and no Q data reaches out_i.
- R5: COEFS packs h[0]..h[NTAPS/2−1] as signed CW-bit fields, h[k] at bits k·CW upward. The upper half mirrors it: h[NTAPS−1−k] = h[k].
- R6: Rounding adds 2^(FRAC−1) to the full-precision sum and then shifts arithmetically right by FRAC, so exact halves round toward +∞.
- R7: A rounded value above 2^(OW−1)−1 outputs 2^(OW−1)−1. A value below −2^(OW−1) outputs −2^(OW−1).
- R8: Input values presented while in_valid is 0 are ignored. They change neither the decimation phase nor any later output.
- R9: Valid samples may arrive back-to-back or with idle gaps of any length, and the results are unchanged.
- R10: out_i and out_q change only in the cycle where out_valid is 1 and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW | In-phase input sample, signed |
| in_q | input | DW | Quadrature input sample, signed |
| out_valid | output | 1 | One-cycle pulse when a decimated result pair is presented |
| out_i | output | OW | Filtered, decimated in-phase sample, signed |
| out_q | output | OW | Filtered, decimated quadrature sample, signed |

## Verification
A wrong branch-select phase or a bad capture mapping moves the decimation instant or scrambles the window order. This shows up as wrong out_i/out_q values at the very first pulse after an impulse, and each impulse position is checked against its own coefficient. A controller that skips or repeats a state shows up within the same four-cycle window, as a missing, doubled or late out_valid pulse or as a value with half its coefficient pairs missing. Errors in rounding, saturation, or I/Q steering show up on the next pulse after a stimulus that hits exactly half an LSB, full scale, or only one channel.

// File: rtl/polydec4_pkg.sv
package polydec4_pkg;

    // number of polyphase branches, equal to the decimation factor
    localparam int BRANCHES = 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_I_LO = 3'd1,
        ST_I_HI = 3'd2,
        ST_Q_LO = 3'd3,
        ST_Q_HI = 3'd4
    } fir_state_t;

endpackage

// File: rtl/polydec4_ctrl.sv
module polydec4_ctrl
    import polydec4_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic [1:0] wr_sel,
    output logic       snap,
    output logic       sel_q,
    output logic       half_hi,
    output logic       acc_load,
    output logic       take_i,
    output logic       take_q
);

    fir_state_t state;
    fir_state_t state_nxt;
    logic [1:0] phase;

    // round-robin branch pointer, advances only on accepted samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= 2'd0;
        end else if (in_valid) begin
            phase <= phase + 2'd1;
        end
    end

    assign wr_sel = phase;
    assign snap   = in_valid && (phase == 2'(BRANCHES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE: state_nxt = snap ? ST_I_LO : ST_IDLE;
            ST_I_LO: state_nxt = ST_I_HI;
            ST_I_HI: state_nxt = ST_Q_LO;
            ST_Q_LO: state_nxt = ST_Q_HI;
            ST_Q_HI: state_nxt = snap ? ST_I_LO : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        sel_q    = 1'b0;
        half_hi  = 1'b0;
        acc_load = 1'b0;
        take_i   = 1'b0;
        take_q   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_I_LO: acc_load = 1'b1;
            ST_I_HI: begin
                half_hi = 1'b1;
                take_i  = 1'b1;
            end
            ST_Q_LO: begin
                sel_q    = 1'b1;
                acc_load = 1'b1;
            end
            ST_Q_HI: begin
                sel_q   = 1'b1;
                half_hi = 1'b1;
                take_q  = 1'b1;
            end
            default: ;
        endcase
    end

    // a capture may only arrive when the datapath is free (R9)
    assert_capture_when_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snap |-> (state == ST_IDLE || state == ST_Q_HI));

    // idle inputs leave the branch pointer alone (R8)
    assert_phase_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(wr_sel));

endmodule

// File: rtl/polydec4_branch_bank.sv
module polydec4_branch_bank #(
    parameter int DW    = 12,
    parameter int NTAPS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic signed [DW-1:0]   din,
    input  logic                   snap,
    output logic [NTAPS*DW-1:0]    window
);

    localparam int DEPTH = NTAPS / 4;

    logic signed [DW-1:0] line [4][DEPTH];
    logic signed [DW-1:0] cap_src [NTAPS];
    logic signed [DW-1:0] hold [NTAPS];

    // four branch delay lines, one selected per accepted sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 4; b++) begin
                for (int j = 0; j < DEPTH; j++) begin
                    line[b][j] <= '0;
                end
            end
        end else if (wr_en) begin
            for (int b = 0; b < 4; b++) begin
                if (wr_sel == 2'(b)) begin
                    line[b][0] <= din;
                    for (int j = 1; j < DEPTH; j++) begin
                        line[b][j] <= line[b][j-1];
                    end
                end
            end
        end
    end

    // window slot d (d=0 newest) lives in branch 3-(d%4), position d/4.
    // the capture coincides with the write into branch 3, so that branch
    // is read in its post-write form.
    for (genvar d = 0; d < NTAPS; d++) begin : g_src
        localparam int BR = 3 - (d % 4);
        localparam int POS = d / 4;
        if (BR == 3 && POS == 0) begin : g_new
            assign cap_src[d] = din;
        end else if (BR == 3) begin : g_shift
            assign cap_src[d] = line[3][POS-1];
        end else begin : g_plain
            assign cap_src[d] = line[BR][POS];
        end
        assign window[d*DW +: DW] = hold[d];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < NTAPS; d++) begin
                hold[d] <= '0;
            end
        end else if (snap) begin
            for (int d = 0; d < NTAPS; d++) begin
                hold[d] <= cap_src[d];
            end
        end
    end

endmodule

// File: rtl/polydec4_mac.sv
module polydec4_mac #(
    parameter int DW    = 12,
    parameter int CW    = 12,
    parameter int NTAPS = 16,
    parameter int ACCW  = 29
) (
    input  logic [NTAPS*DW-1:0]     window,
    input  logic [NTAPS/2*CW-1:0]   coefs,
    input  logic                    half_hi,
    output logic signed [ACCW-1:0]  partial
);

    localparam int LANES = NTAPS / 4;
    localparam int PW    = DW + CW + 1;

    logic signed [PW-1:0] prod [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int KLO = j;
        localparam int KHI = LANES + j;
        logic signed [DW-1:0] a_lo, b_lo, a_hi, b_hi;
        logic signed [DW:0]   pre;
        logic signed [CW-1:0] cf;

        assign a_lo = window[KLO*DW +: DW];
        assign b_lo = window[(NTAPS-1-KLO)*DW +: DW];
        assign a_hi = window[KHI*DW +: DW];
        assign b_hi = window[(NTAPS-1-KHI)*DW +: DW];

        // pair sharing one coefficient is summed before the multiply
        assign pre = half_hi ? ({a_hi[DW-1], a_hi} + {b_hi[DW-1], b_hi})
                             : ({a_lo[DW-1], a_lo} + {b_lo[DW-1], b_lo});
        assign cf  = half_hi ? coefs[KHI*CW +: CW] : coefs[KLO*CW +: CW];
        assign prod[j] = PW'(pre) * PW'(cf);
    end

    always_comb begin
        partial = '0;
        for (int j = 0; j < LANES; j++) begin
            partial = partial + ACCW'(prod[j]);
        end
    end

endmodule

// File: rtl/polydec4_iq_fir.sv
module polydec4_iq_fir
    import polydec4_pkg::*;
#(
    parameter int DW    = 12,
    parameter int OW    = 12,
    parameter int CW    = 12,
    parameter int NTAPS = 16,
    parameter int FRAC  = 11,
    parameter logic [NTAPS/2*CW-1:0] COEFS = {12'h230, 12'h1E0, 12'h154, 12'h0B4,
                                              12'h03C, 12'hFF6, 12'hFEC, 12'hFF8}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_i,
    output logic signed [OW-1:0] out_q
);

    localparam int ACCW = DW + CW + $clog2(NTAPS/2) + 2;
    localparam logic signed [ACCW-1:0] RND_HALF = ACCW'(1) <<< (FRAC - 1);
    localparam logic signed [ACCW-1:0] OUT_MAX  = (ACCW'(1) <<< (OW - 1)) - ACCW'(1);
    localparam logic signed [ACCW-1:0] OUT_MIN  = ~OUT_MAX;

    logic [1:0]             wr_sel;
    logic                   snap, sel_q, half_hi, acc_load, take_i, take_q;
    logic [NTAPS*DW-1:0]    win_i, win_q, win_sel;
    logic signed [ACCW-1:0] partial, acc, total, biased, shifted;
    logic signed [OW-1:0]   sat_val, i_pend;

    polydec4_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .wr_sel   (wr_sel),
        .snap     (snap),
        .sel_q    (sel_q),
        .half_hi  (half_hi),
        .acc_load (acc_load),
        .take_i   (take_i),
        .take_q   (take_q)
    );

    polydec4_branch_bank #(.DW(DW), .NTAPS(NTAPS)) u_bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_sel(wr_sel),
        .din(in_i), .snap(snap), .window(win_i)
    );

    polydec4_branch_bank #(.DW(DW), .NTAPS(NTAPS)) u_bank_q (
        .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_sel(wr_sel),
        .din(in_q), .snap(snap), .window(win_q)
    );

    assign win_sel = sel_q ? win_q : win_i;

    polydec4_mac #(.DW(DW), .CW(CW), .NTAPS(NTAPS), .ACCW(ACCW)) u_mac (
        .window  (win_sel),
        .coefs   (COEFS),
        .half_hi (half_hi),
        .partial (partial)
    );

    // accumulator cleared (overwritten) at the start of each channel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (acc_load) begin
            acc <= partial;
        end
    end

    assign total   = acc + partial;
    assign biased  = total + RND_HALF;
    assign shifted = biased >>> FRAC;

    always_comb begin
        if (shifted > OUT_MAX) begin
            sat_val = OW'(OUT_MAX);
        end else if (shifted < OUT_MIN) begin
            sat_val = OW'(OUT_MIN);
        end else begin
            sat_val = OW'(shifted);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_pend    <= '0;
            out_i     <= '0;
            out_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= take_q;
            if (take_i) begin
                i_pend <= sat_val;
            end
            if (take_q) begin
                out_i <= i_pend;
                out_q <= sat_val;
            end
        end
    end

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_pulse_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(take_q));

    assert_outputs_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));

endmodule

// File: tb/polydec4_iq_fir_tb_top.sv
`timescale 1ns/1ps
module polydec4_iq_fir_tb_top;

    localparam int DW = 12;
    localparam int OW = 12;
    localparam int CW = 12;
    localparam int NT = 16;
    localparam int FRAC = 11;
    // first-half coefficients h[0..7], packed h[k] at bits k*CW (R5)
    localparam logic [NT/2*CW-1:0] TB_COEFS = {12'h230, 12'h1E0, 12'h154, 12'h0B4,
                                               12'h03C, 12'hFF6, 12'hFEC, 12'hFF8};
    int hh [NT/2] = '{-8, -20, -10, 60, 180, 340, 480, 560};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_i = '0, in_q = '0;
    logic out_valid;
    logic signed [OW-1:0] out_i, out_q;

    always #2.5 clk = ~clk;

    polydec4_iq_fir #(.DW(DW), .OW(OW), .CW(CW), .NTAPS(NT), .FRAC(FRAC),
                      .COEFS(TB_COEFS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int accepted = 0;
    int hist_i [NT];
    int hist_q [NT];
    int exp_cyc [$];
    int exp_i [$];
    int exp_q [$];
    logic seen_any = 1'b0;
    logic signed [OW-1:0] last_i = '0, last_q = '0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    // independent model: direct-form filter, rounding and saturation (R3 R5 R6 R7)
    function automatic int model(input int h [NT]);
        longint acc = 0;
        longint r;
        for (int t = 0; t < NT; t++) begin
            int c = (t < NT/2) ? hh[t] : hh[NT-1-t];
            acc += longint'(c) * longint'(h[t]);
        end
        r = (acc + (longint'(1) << (FRAC-1))) >>> FRAC;
        if (r > 2047) r = 2047;
        if (r < -2048) r = -2048;
        return int'(r);
    endfunction

    // monitor, samples away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_cyc.size() == 0) begin
                    check(1'b0, "R2 unexpected out_valid pulse", 1, 0);
                end else begin
                    int ec, ei, eq;
                    ec = exp_cyc.pop_front();
                    ei = exp_i.pop_front();
                    eq = exp_q.pop_front();
                    check(cyc == ec, "R2 pulse cycle", cyc, ec);
                    check(int'(out_i) == ei, "R3/R6/R7 out_i", int'(out_i), ei);
                    check(int'(out_q) == eq, "R4/R6/R7 out_q", int'(out_q), eq);
                end
                last_i <= out_i;
                last_q <= out_q;
                seen_any <= 1'b1;
            end else if (seen_any) begin
                check(out_i == last_i && out_q == last_q, "R10 hold out_i",
                      int'(out_i), int'(last_i));
            end
        end
    end

    task automatic send(input int vi, input int vq);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_i = DW'(vi);
        in_q = DW'(vq);
        for (int t = NT-1; t > 0; t--) begin
            hist_i[t] = hist_i[t-1];
            hist_q[t] = hist_q[t-1];
        end
        hist_i[0] = vi;
        hist_q[0] = vq;
        accepted++;
        if (accepted % 4 == 0) begin
            exp_cyc.push_back(cyc + 5);
            exp_i.push_back(model(hist_i));
            exp_q.push_back(model(hist_q));
        end
    endtask

    // idle cycles with garbage on the data inputs (R8)
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            in_i = DW'(lfsr);
            in_q = DW'(~lfsr);
        end
    endtask

    task automatic drain(input string tag);
        idle(8);
        check(exp_cyc.size() == 0, {tag, " R2 all pulses seen"}, exp_cyc.size(), 0);
    endtask

    task automatic t_reset;
        for (int t = 0; t < NT; t++) begin hist_i[t] = 0; hist_q[t] = 0; end
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(out_i == 0, "R1 out_i in reset", int'(out_i), 0);
        check(out_q == 0, "R1 out_q in reset", int'(out_q), 0);
        rst_n = 1'b1;
        idle(3);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    endtask

    // impulses at every phase and several amplitudes; -128 and 128 hit exact halves (R6)
    task automatic t_impulse;
        int amps [4] = '{100, -128, 128, 1000};
        foreach (amps[a]) begin
            for (int p = 0; p < 4; p++) begin
                for (int k = 0; k < p; k++) send(0, 0);
                send(amps[a], 0);
                for (int k = 0; k < NT + 4 - p; k++) send(0, 0);
                // Q-only impulse checks steering (R4)
                send(0, -amps[a]);
                for (int k = 0; k < NT + 3; k++) send(0, 0);
            end
        end
        drain("impulse");
    endtask

    // full-scale constants exceed the output range (R7)
    task automatic t_saturate;
        for (int k = 0; k < 3 * NT; k++) send(2047, -2048);
        for (int k = 0; k < 2 * NT; k++) send(-2048, 2047);
        drain("saturate");
    endtask

    // pseudo-random data, back-to-back (R3 R4)
    task automatic t_random;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(int'($signed(lfsr[11:0])), int'($signed(lfsr[15:4])));
        end
        drain("random");
    endtask

    // random gaps with garbage while idle (R8 R9)
    task automatic t_gaps;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(int'($signed(lfsr[13:2])), int'($signed(lfsr[11:0])) >>> 2);
            idle(int'(lfsr[2:0]) % 6);
        end
        drain("gaps");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_impulse();
                t_saturate();
                t_random();
                t_gaps();
            end
            begin
                repeat (150000) @(posedge clk);
                check(1'b0, "R2 watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule